// File: doc/BRIEF.md
# Divide-by-3 Phase-Order Corrector with Reset-Release Delay Search

A fully differential divide-by-3 stage is built from two 33%-duty dividers, one clocked on each half of the input clock. Their six outputs are only useful when they interleave in the order A, F, B, D, C, E. After power-up the second (slave) divider may start in the wrong slot. This block watches two of the phases. It checks the level of E at each rising edge of A. At a slow check rate, derived by dividing the A rising edges by four, it resets the slave divider whenever the last check found E low.

The point in time where that reset is released decides which slot the slave divider restarts in. For that reason each issued reset is stretched by a delay of N steps, and N grows by one after every failed check. Once a check passes, no more resets are issued and N stays frozen at the value that worked. In this model one delay step is one cycle of a fast timing clock. All inputs are sampled on that clock.

Top module: `phase_order_corrector`

## Requirements
- R1: During and right after global reset (`rst_n` low), `slave_rst` is 0, `n_code` is 0 (meaning N = 1) and `cal_fail` is 0.
- R2: On each rising edge of `ph_a` the block records the level of `ph_e`. On every fourth rising edge of `ph_a`, counted from reset, a record of `ph_e` low starts a reset pulse and a record of `ph_e` high starts none. If the phases start in the correct order, no pulse is ever issued.
- R3: A reset pulse keeps `slave_rst` high for exactly PW + N consecutive fast-clock cycles. N = `n_code` + 1 is taken from the value of `n_code` before the pulse, and PW defaults to 1.
- R4: When a pulse starts, `n_code` increases by exactly one in the same cycle, unless it is already at its maximum (15).
- R5: `n_code` changes only when a pulse starts. Once checks pass, it keeps its last value.
- R6: If a failure is found while `n_code` is 15, `n_code` stays at 15 and `cal_fail` goes to 1. `cal_fail` then stays at 1 until global reset.
- R7: From any wrong starting alignment of the slave divider, the loop converges. Resets stop, `cal_fail` stays 0, and the six phases cycle in the order A, F, B, D, C, E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast timing clock; one cycle is one delay step |
| rst_n | input | 1 | Global reset, active low |
| ph_a | input | 1 | Phase A from the master divider, synchronous to clk_fast |
| ph_e | input | 1 | Phase E from the slave divider, synchronous to clk_fast |
| slave_rst | output | 1 | Reset for the slave divider, with stretched release |
| n_code | output | DW (4) | Delay code; N = n_code + 1 |
| cal_fail | output | 1 | Sticky flag: failure found with the delay code at its maximum |

## Verification
The assertions assume three things about the inputs. `ph_a` and `ph_e` are already synchronous to `clk_fast`. A rising edge of `ph_a` comes far enough after the previous one that a group of four edges is longer than the longest stretched pulse. Phase E is meaningful only while no slave reset is active. The bench keeps within these limits by building the two dividers itself on `clk_fast`: one advances on even cycles and the other on odd cycles, so each divider state lasts two cycles and a group of four A edges spans 24 cycles. The bench sweeps all nine starting pairs of master and slave state. It also ties E low to force the delay search into saturation.

// File: rtl/phase_order_corrector.sv
module phase_order_corrector #(
  parameter int DW  = 4,
  parameter int PW  = 1,
  parameter int GRP = 4
) (
  input  logic          clk_fast,
  input  logic          rst_n,
  input  logic          ph_a,
  input  logic          ph_e,
  output logic          slave_rst,
  output logic [DW-1:0] n_code,
  output logic          cal_fail
);
  localparam int GW = (GRP > 1) ? $clog2(GRP) : 1;
  localparam int RW = $clog2(PW + (1 << DW) + 1);

  logic          a_q, err_q, tick_q;
  logic [GW-1:0] grp_q;
  logic [RW-1:0] hold_q;

  wire a_rise = ph_a & ~a_q;
  wire tick   = a_rise && (grp_q == GW'(GRP - 1));
  wire fire   = tick_q && err_q && (hold_q == '0);
  wire at_max = &n_code;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= 1'b0;
      err_q    <= 1'b0;
      tick_q   <= 1'b0;
      grp_q    <= '0;
      hold_q   <= '0;
      n_code   <= '0;
      cal_fail <= 1'b0;
    end else begin
      a_q    <= ph_a;
      tick_q <= tick;
      if (a_rise) begin
        err_q <= ~ph_e;
        grp_q <= tick ? '0 : grp_q + 1'b1;
      end
      if (fire) begin
        hold_q <= RW'(PW) + RW'(n_code) + RW'(1);
        if (at_max) cal_fail <= 1'b1;
        else        n_code   <= n_code + 1'b1;
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign slave_rst = (hold_q != '0);
endmodule

// File: rtl/phase_order_corrector_chk.sv
module phase_order_corrector_chk #(
  parameter int DW = 4,
  parameter int PW = 1
) (
  input logic          clk_fast,
  input logic          rst_n,
  input logic          slave_rst,
  input logic [DW-1:0] n_code,
  input logic          cal_fail
);
  int run;
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else        run <= slave_rst ? run + 1 : 0;
  end

  AST_RST_WIDTH: assert property (@(posedge clk_fast) disable iff (!rst_n)
    run <= PW + (1 << DW)); // R3
  AST_CODE_STEP: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(n_code) |-> (n_code == $past(n_code) + 1'b1)); // R4
  AST_CODE_ON_PULSE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(n_code) |-> $rose(slave_rst)); // R5
  AST_FAIL_STICKY: assert property (@(posedge clk_fast) disable iff (!rst_n)
    cal_fail |=> cal_fail); // R6
  AST_FAIL_AT_MAX: assert property (@(posedge clk_fast) disable iff (!rst_n)
    cal_fail |-> (&n_code)); // R6
endmodule

bind phase_order_corrector phase_order_corrector_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk_fast (clk_fast),
  .rst_n    (rst_n),
  .slave_rst(slave_rst),
  .n_code   (n_code),
  .cal_fail (cal_fail)
);

// File: tb/sim_phase_order_corrector.sv
module sim_phase_order_corrector;
  localparam int CLK_T = 10;
  localparam int DW = 4;
  localparam int PW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] sp, sm, init_sp = 2'd0, init_sm = 2'd0;
  logic tog, kill_e = 1'b0;
  logic slave_rst, cal_fail;
  logic [DW-1:0] n_code;

  int chk = 0, fail = 0;
  int mon_chk = 0, mon_fail = 0, pulses = 0;

  always #(CLK_T/2) clk = ~clk;

  wire ph_a = (sp == 2'd0);
  wire ph_b = (sp == 2'd1);
  wire ph_c = (sp == 2'd2);
  wire ph_f = (sm == 2'd0);
  wire ph_d = (sm == 2'd1);
  wire ph_e = (sm == 2'd2) & ~kill_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= init_sp; sm <= init_sm; tog <= 1'b0;
    end else begin
      tog <= ~tog;
      if (!tog) sp <= (sp == 2'd2) ? 2'd0 : sp + 2'd1;
      if (slave_rst) sm <= 2'd0;
      else if (tog) sm <= (sm == 2'd2) ? 2'd0 : sm + 2'd1;
    end
  end

  phase_order_corrector #(.DW(DW), .PW(PW)) u0 (
    .clk_fast(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_e(ph_e),
    .slave_rst(slave_rst), .n_code(n_code), .cal_fail(cal_fail)
  );

  // pulse monitor: R3 width, R4 code step
  logic rst_prev = 1'b0;
  int run = 0, exp_w = 0, prev_code = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pulses <= 0; run = 0; rst_prev = 1'b0;
    end else begin
      if (slave_rst && !rst_prev) begin
        pulses <= pulses + 1;
        exp_w = PW + prev_code + 1;
        mon_chk <= mon_chk + 1;
        if (int'(n_code) != ((prev_code == 15) ? 15 : prev_code + 1)) begin
          mon_fail <= mon_fail + 1;
          $display("FAIL R4 code at pulse start act=%0d exp=%0d", n_code,
                   (prev_code == 15) ? 15 : prev_code + 1);
        end
        run = 1;
      end else if (slave_rst) begin
        run = run + 1;
      end else if (rst_prev) begin
        mon_chk <= mon_chk + 1;
        if (run != exp_w) begin
          mon_fail <= mon_fail + 1;
          $display("FAIL R3 pulse width act=%0d exp=%0d", run, exp_w);
        end
      end
      rst_prev = slave_rst;
    end
    prev_code = int'(n_code);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chk++;
    if (!ok) begin
      fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s0, input logic [1:0] m0);
    @(negedge clk);
    rst_n = 1'b0; init_sp = s0; init_sm = m0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R7 ordering: each rising phase must be the successor of the previous one
  task automatic check_order();
    logic [5:0] cur, prv;
    int last = -1;
    bit ok = 1'b1;
    prv = {ph_e, ph_c, ph_d, ph_b, ph_f, ph_a};
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      cur = {ph_e, ph_c, ph_d, ph_b, ph_f, ph_a};
      for (int k = 0; k < 6; k++) begin
        if (cur[k] && !prv[k]) begin
          if (last >= 0 && k != (last + 1) % 6) ok = 1'b0;
          last = k;
        end
      end
      prv = cur;
    end
    check(ok && last >= 0, "R7 phase order A,F,B,D,C,E", int'(ok), 1);
  endtask

  initial begin
    int quiet;
    logic [DW-1:0] code_hold;
    // R1 reset state
    do_reset(2'd0, 2'd0);
    check(slave_rst == 1'b0, "R1 slave_rst after reset", slave_rst, 0);
    check(n_code == '0, "R1 n_code after reset", n_code, 0);
    check(cal_fail == 1'b0, "R1 cal_fail after reset", cal_fail, 0);

    // sweep all starting alignments
    for (int s = 0; s < 3; s++) begin
      for (int m = 0; m < 3; m++) begin
        do_reset(2'(s), 2'(m));
        repeat (800) @(negedge clk);
        if (s == m) begin
          check(pulses == 0, "R2 no pulse when order correct", pulses, 0);
          check(n_code == '0, "R2 code untouched when order correct", n_code, 0);
        end else begin
          check(pulses >= 1, "R2 pulse on wrong order", pulses, 1);
        end
        code_hold = n_code;
        quiet = 0;
        for (int i = 0; i < 200; i++) begin
          @(negedge clk);
          if (!slave_rst) quiet++;
        end
        check(quiet == 200, "R7 no resets after convergence", quiet, 200);
        check(n_code == code_hold, "R5 code frozen after pass", n_code, code_hold);
        check(cal_fail == 1'b0, "R7 no cal_fail on convergence", cal_fail, 0);
        check_order();
      end
    end

    // forced persistent failure: saturation
    kill_e = 1'b1;
    do_reset(2'd0, 2'd0);
    for (int k = 1; k <= 17; k++) begin
      quiet = 0;
      while (pulses < k && quiet < 400) begin
        @(negedge clk);
        quiet++;
      end
      @(negedge clk);
      check(int'(n_code) == ((k > 15) ? 15 : k), "R4 R6 code after k failures",
            n_code, (k > 15) ? 15 : k);
      check(cal_fail == (k >= 16), "R6 cal_fail after k failures", cal_fail, int'(k >= 16));
    end
    kill_e = 1'b0;
    repeat (100) @(negedge clk);
    check(cal_fail == 1'b1, "R6 cal_fail sticky", cal_fail, 1);
    do_reset(2'd1, 2'd1);
    @(negedge clk);
    check(cal_fail == 1'b0 && n_code == '0, "R1 reset clears fail and code",
          {cal_fail, n_code}, 0);
    repeat (400) @(negedge clk);
    check(pulses == 0, "R2 aligned start after fail", pulses, 0);

    chk += mon_chk;
    fail += mon_fail;
    check(mon_chk > 0, "R3 pulses observed", mon_chk, 1);
    $display("TB_RESULT checks=%0d failures=%0d", chk, fail);
    $finish;
  end

  initial begin
    #(CLK_T * 150000);
    $display("FAIL watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", chk + mon_chk + 1, fail + mon_fail + 1);
    $finish;
  end
endmodule